// File: doc/BRIEF.md
# Dual Down-Counting Timer

This peripheral holds two independent 32-bit down-counters behind a small synchronous register port. Each counter either stops after it expires (one-shot) or wraps back to a programmed reload value (periodic). Each counter advances on count ticks. A tick comes from the system clock divided by a power of two, or from an external reference tick input, chosen per timer.

When a counter expires it sets a sticky per-timer event flag. The flag drives that timer's interrupt line until software clears it. Software starts a one-shot count by writing the live value register. It can get a free-running counter by loading all ones into both the reload and value registers with reload enabled. Reads are combinational: `rd_data` follows `addr` in the same cycle.

Top module: `dual_countdown_timer`

## Requirements
- R1: After reset every register reads 0 and both interrupt lines are low.
- R2: The control word at offset 0x00 stores only its defined fields and reads 0x01F8180F after writing all ones. The fields are:
  - enable: bit 0 for timer 0, bit 2 for timer 1.
  - reload-enable: bit 1 for timer 0, bit 3 for timer 1.
  - reference-select: bit 11 for timer 0, bit 12 for timer 1.
  - 3-bit divider exponent: bits 21:19 for timer 0, bits 24:22 for timer 1.
- R3: In one-shot mode, a counter loaded through its value register (0x14 for timer 0, 0x1C for timer 1) with V counts down on each tick. Its event is raised on the tick that finds it at 0, so it takes V+1 ticks. The counter then stays at 0 and raises no further event.
- R4: With the system clock selected and divider exponent n, one tick occurs every 2^n clocks. The first tick comes 2^n clocks after enable, because the prescaler restarts whenever the timer is disabled. So the event is visible (V+1)·2^n clocks after the enabling write.
- R5: With reload enabled, a counter that expires reloads from its reload register (0x10 for timer 0, 0x18 for timer 1), giving a period of reload+1 ticks.
- R6: With reload enabled and 0xFFFFFFFF in both the value and reload registers, the value decreases by one every tick, and a read returns the live count.
- R7: With reference-select set, the counter advances only on cycles where `ref_tick` is high, and the divider exponent has no effect.
- R8: Clearing the enable bit freezes the value register at its current count.
- R9: The event status word at offset 0x04 shows timer 0 at bit 0 and timer 1 at bit 8. A write clears each event bit written as 0 and leaves each bit written as 1 unchanged.
- R10: If a timer expires in the same cycle as a write that clears its event bit, the flag stays set.
- R11: Each interrupt line equals its timer's event flag.
- R12: Addresses other than 0x00, 0x04, 0x10, 0x14, 0x18 and 0x1C read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Reference count pulse, already in the clk domain |
| addr | input | ADDR_W | Register byte address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| irq | output | 2 | Interrupt per timer, bit i for timer i |

## Verification
A hardware expiry and a software clearing write to the status word can land in the same cycle. The bench provokes this by running timer 0 periodically with a reload of 3. It then times the clearing write to be active in exactly the cycle where the count sits at 0 and a tick occurs. The interrupt must still be high afterwards. A second clearing write one cycle after an expiry must then drop it. Together these show that the set takes precedence and that the clear still works when the two do not collide.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int REG_W = 32;
  localparam int DIV_W = 3;
  localparam int NUM_TMR = 2;

  localparam int OFF_CTRL = 'h00;
  localparam int OFF_STAT = 'h04;

  // Register offsets per timer
  function automatic int reload_off(input int i);
    return 'h10 + 8 * i;
  endfunction

  function automatic int value_off(input int i);
    return 'h14 + 8 * i;
  endfunction

  // Control-word field positions per timer
  function automatic int en_pos(input int i);
    return 2 * i;
  endfunction

  function automatic int rl_pos(input int i);
    return 2 * i + 1;
  endfunction

  function automatic int ref_pos(input int i);
    return 11 + i;
  endfunction

  function automatic int div_pos(input int i);
    return 19 + DIV_W * i;
  endfunction

  // Event bit position in the status word
  function automatic int stat_pos(input int i);
    return 8 * i;
  endfunction

  // Bits of the control word that are stored
  function automatic logic [REG_W-1:0] ctrl_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      m[en_pos(i)]  = 1'b1;
      m[rl_pos(i)]  = 1'b1;
      m[ref_pos(i)] = 1'b1;
      for (int b = 0; b < DIV_W; b++) m[div_pos(i) + b] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 16,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             use_ref,
  input  logic             ref_tick,
  input  logic [DIV_W-1:0] div_exp,
  output logic             tick
);

  logic [PRE_W-1:0] pre_q;
  logic             sys_tick;

  // True when the low n bits of the count are all ones
  function automatic logic low_ones(input logic [PRE_W-1:0] c,
                                    input logic [DIV_W-1:0] n);
    logic [PRE_W-1:0] m;
    m = ~({PRE_W{1'b1}} << n);
    return (c & m) == m;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   pre_q <= '0;
    else if (!run) pre_q <= '0;
    else          pre_q <= pre_q + 1'b1;
  end

  assign sys_tick = run && low_ones(pre_q, div_exp);
  assign tick     = run && (use_ref ? ref_tick : sys_tick);

  // R4: with n >= 1, two system ticks are never back to back
  assert_div_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_tick && div_exp != '0) |=> (!sys_tick || !run || !$stable(div_exp)));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reload_en,
  input  logic             val_we,
  input  logic [CNT_W-1:0] val_wdata,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign expire  = tick && at_zero && (reload_en || !done_q);
  assign count   = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (val_we) begin
      cnt_q  <= val_wdata;
      done_q <= 1'b0;
    end else if (tick) begin
      if (at_zero) begin
        if (reload_en) begin
          cnt_q  <= reload_val;
          done_q <= 1'b0;
        end else begin
          done_q <= 1'b1;
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R8: without a tick or a write the count holds
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !val_we) |=> $stable(cnt_q));

  // R5: a periodic expiry lands on the reload value
  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && reload_en && !val_we) |=> (cnt_q == $past(reload_val)));

  // R3: a finished one-shot does not fire again
  assert_oneshot_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !reload_en && !val_we) |=> (!expire || reload_en));

endmodule

// File: rtl/tmr_event_flag.sv
module tmr_event_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  always_ff @(posedge clk) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // R10: an expiry always leaves the flag set
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);

  // R9: a lone clear drops the flag
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);

endmodule

// File: rtl/dual_countdown_timer.sv
module dual_countdown_timer
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PRE_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic [NUM_TMR-1:0] irq
);

  localparam logic [REG_W-1:0] CTRL_MASK = ctrl_mask();

  logic [REG_W-1:0]   ctrl_q;
  logic [REG_W-1:0]   reload_q [NUM_TMR];
  logic [REG_W-1:0]   count_w  [NUM_TMR];
  logic [NUM_TMR-1:0] tick_w, expire_w, flag_w, clr_w, val_we_w, rld_we_w;
  logic               hit_ctrl, hit_stat, addr_mapped, addr_unmapped;

  assign hit_ctrl = wr_en && (addr == ADDR_W'(OFF_CTRL));
  assign hit_stat = wr_en && (addr == ADDR_W'(OFF_STAT));

  always_ff @(posedge clk) begin
    if (!rst_n)        ctrl_q <= '0;
    else if (hit_ctrl) ctrl_q <= wr_data & CTRL_MASK;
  end

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    assign rld_we_w[i] = wr_en && (addr == ADDR_W'(reload_off(i)));
    assign val_we_w[i] = wr_en && (addr == ADDR_W'(value_off(i)));
    assign clr_w[i]    = hit_stat && !wr_data[stat_pos(i)];

    always_ff @(posedge clk) begin
      if (!rst_n)           reload_q[i] <= '0;
      else if (rld_we_w[i]) reload_q[i] <= wr_data;
    end

    tmr_prescaler #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (ctrl_q[en_pos(i)]),
      .use_ref  (ctrl_q[ref_pos(i)]),
      .ref_tick (ref_tick),
      .div_exp  (ctrl_q[div_pos(i) +: DIV_W]),
      .tick     (tick_w[i])
    );

    tmr_counter #(.CNT_W(REG_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick_w[i]),
      .reload_en  (ctrl_q[rl_pos(i)]),
      .val_we     (val_we_w[i]),
      .val_wdata  (wr_data),
      .reload_val (reload_q[i]),
      .count      (count_w[i]),
      .expire     (expire_w[i])
    );

    tmr_event_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (expire_w[i]),
      .clr_i  (clr_w[i]),
      .flag_o (flag_w[i])
    );

    assign irq[i] = flag_w[i];
  end

  always_comb begin
    rd_data     = '0;
    addr_mapped = 1'b0;
    if (addr == ADDR_W'(OFF_CTRL)) begin
      rd_data     = ctrl_q;
      addr_mapped = 1'b1;
    end
    if (addr == ADDR_W'(OFF_STAT)) begin
      addr_mapped = 1'b1;
      for (int i = 0; i < NUM_TMR; i++) rd_data[stat_pos(i)] = flag_w[i];
    end
    for (int i = 0; i < NUM_TMR; i++) begin
      if (addr == ADDR_W'(reload_off(i))) begin
        rd_data     = reload_q[i];
        addr_mapped = 1'b1;
      end
      if (addr == ADDR_W'(value_off(i))) begin
        rd_data     = count_w[i];
        addr_mapped = 1'b1;
      end
    end
  end

  assign addr_unmapped = !addr_mapped;

  // R12: a write to an unused address leaves control and reload state alone
  assert_unmapped_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr_unmapped) |=>
      ($stable(ctrl_q) && $stable(reload_q[0]) && $stable(reload_q[1])));

endmodule

// File: tb/test_dual_countdown_timer.sv
module test_dual_countdown_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [1:0]  irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dual_countdown_timer i_dual_countdown_timer (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h04;

  function automatic logic [7:0] a_rld(input int t); return 8'h10 + 8'(8 * t); endfunction
  function automatic logic [7:0] a_val(input int t); return 8'h14 + 8'(8 * t); endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive a write during one cycle; returns at the negedge after the edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rd_data;
  endtask

  initial begin
    logic [31:0] v;
    int cycles;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CTRL, v);   check("R1 ctrl", v, 0);
    rd(A_STAT, v);   check("R1 stat", v, 0);
    rd(a_val(0), v); check("R1 val0", v, 0);
    rd(a_val(1), v); check("R1 val1", v, 0);
    rd(a_rld(0), v); check("R1 rld0", v, 0);
    rd(a_rld(1), v); check("R1 rld1", v, 0);
    check("R1 irq", {30'b0, irq}, 0);

    // R3/R4 sweep: timer, divider exponent, start value
    for (int t = 0; t < 2; t++) begin
      for (int n = 0; n < 4; n++) begin
        for (int sv = 0; sv < 4; sv++) begin
          wr(A_CTRL, 0);
          wr(A_STAT, 0);
          wr(a_val(t), sv);
          wr(A_CTRL, (32'h1 << (2 * t)) | (32'(n) << (19 + 3 * t)));
          cycles = 0;
          while (!irq[t] && cycles < 1000) begin
            @(negedge clk);
            cycles++;
          end
          check("R4 cycles to event", cycles, (sv + 1) << n);
          check("R3 other irq quiet", {31'b0, irq[1-t]}, 0);
          wr(A_STAT, 0);
          repeat ((4 << n) + 2) @(negedge clk);
          rd(a_val(t), v);
          check("R3 stays at zero", v, 0);
          check("R3 no second event", {31'b0, irq[t]}, 0);
        end
      end
    end

    // R5 periodic wrap sequence, reload 2, value 0
    wr(A_CTRL, 0); wr(A_STAT, 0);
    wr(a_val(0), 0); wr(a_rld(0), 2);
    wr(A_CTRL, 32'h3);
    for (int i = 0; i < 7; i++) begin
      rd(a_val(0), v);
      check("R5 wrap sequence", v, (i == 0) ? 0 : 2 - ((i - 1) % 3));
      @(negedge clk);
    end

    // R10 collision, then R9 plain clear
    wr(A_CTRL, 0); wr(A_STAT, 0);
    wr(a_val(0), 0); wr(a_rld(0), 3);
    wr(A_CTRL, 32'h3);
    repeat (3) @(negedge clk);
    check("R11 irq after first expiry", {31'b0, irq[0]}, 1);
    wr(A_STAT, 0);  // active in the cycle of the second expiry
    check("R10 event wins over clear", {31'b0, irq[0]}, 1);
    wr(A_STAT, 0);
    check("R9 lone clear", {31'b0, irq[0]}, 0);

    // R6 free-running
    wr(A_CTRL, 0); wr(A_STAT, 0);
    wr(a_val(1), 32'hFFFF_FFFF); wr(a_rld(1), 32'hFFFF_FFFF);
    wr(A_CTRL, 32'hC);
    for (int k = 0; k < 5; k++) begin
      rd(a_val(1), v);
      check("R6 free run", v, 32'hFFFF_FFFF - 32'(k));
      @(negedge clk);
    end

    // R7 reference tick, divider field set to 3 but ignored
    wr(A_CTRL, 0); wr(A_STAT, 0);
    wr(a_val(1), 2);
    wr(A_CTRL, (32'h1 << 2) | (32'h1 << 12) | (32'h3 << 22));
    repeat (8) @(negedge clk);
    rd(a_val(1), v); check("R7 idle without ref", v, 2);
    check("R7 no irq without ref", {31'b0, irq[1]}, 0);
    for (int p = 0; p < 3; p++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
    end
    rd(a_val(1), v); check("R7 counted ref", v, 0);
    check("R7 irq after three ref ticks", {31'b0, irq[1]}, 1);

    // R8 disable freezes count
    wr(A_CTRL, 0); wr(A_STAT, 0);
    wr(a_val(0), 100);
    wr(A_CTRL, 32'h1);
    repeat (10) @(negedge clk);
    wr(A_CTRL, 0);
    rd(a_val(0), v); check("R8 frozen value", v, 88);
    repeat (5) @(negedge clk);
    rd(a_val(0), v); check("R8 still frozen", v, 88);
    check("R8 no irq", {30'b0, irq}, 0);

    // R9/R11 status clear rule with both flags set
    wr(A_CTRL, 0); wr(A_STAT, 0);
    wr(a_val(0), 0); wr(a_val(1), 0);
    wr(A_CTRL, 32'h5);
    repeat (3) @(negedge clk);
    rd(A_STAT, v); check("R9 both flags", v, 32'h101);
    check("R11 both irq", {30'b0, irq}, 3);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, v); check("R9 ones keep flags", v, 32'h101);
    wr(A_STAT, 32'hFFFF_FFFE);
    rd(A_STAT, v); check("R9 clear bit 0 only", v, 32'h100);
    check("R11 irq follows flags", {30'b0, irq}, 2);
    wr(A_STAT, 32'hFFFF_FEFF);
    rd(A_STAT, v); check("R9 clear bit 8", v, 0);
    check("R11 irq low", {30'b0, irq}, 0);

    // R12 unmapped addresses
    wr(A_CTRL, 0);
    wr(8'h08, 32'hDEAD_BEEF);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h08, v); check("R12 read 0x08", v, 0);
    rd(8'h20, v); check("R12 read 0x20", v, 0);
    rd(A_CTRL, v); check("R12 ctrl untouched", v, 0);
    rd(a_rld(0), v); check("R12 rld0 untouched", v, 3);
    rd(A_STAT, v); check("R12 stat untouched", v, 0);

    // R2 control mask
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); check("R2 ctrl mask", v, 32'h01F8_180F);
    wr(A_CTRL, 0);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule